// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A free-running divider makes a sample tick from the system clock. Each bit period lasts sixteen ticks. A falling edge on the idle-high line starts a frame. The receiver then checks the line again at the centre of the start bit, and a start that has already gone away is dropped. Each data, parity and stop bit is decided by a vote of three samples taken around the bit centre, so a short spike on the line cannot flip a bit.

When the last stop bit has been sampled, the receiver gives out the character on `rx_data` with a one-cycle `rx_valid` strobe. The parity, framing and break flags appear with the same strobe. A frame with every bit low is reported as a break. The receiver then waits for the line to go high again before it looks for the next start. A loopback select feeds the local transmitter output into the receiver in place of the external pin. The line-control inputs are captured at each start edge.

Top module: `uart_rx_vote`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rx_valid`, `rx_data`, `parity_err`, `frame_err` and `break_det` are all zero.
- R2: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits. `rx_valid` is high for exactly one clock per frame. `rx_data` and the flags keep their value until the next strobe.
- R3: `char_len` sets the data length: 2'b00 is 5 bits, 2'b01 is 6, 2'b10 is 7 and 2'b11 is 8. Bits of `rx_data` above the length read as zero.
- R4: `par_mode[0]` enables parity. `par_mode[1]` selects even parity when 1 and odd parity when 0. Even parity means the data bits and the parity bit together hold an even number of ones. `parity_err` is set when the received parity bit does not match. It is never set while parity is disabled.
- R5: If the line has gone back high at the middle sample (tick 8) of the start bit, no character is produced, and the receiver is ready for the next start.
- R6: Each bit takes the majority value of its samples at ticks 7, 8 and 9. A spike that changes only one of these samples does not change the received bit.
- R7: `frame_err` is set when a stop bit is sampled as 0. When `stop_two` is 1, two stop bits are expected, and `frame_err` is set if either of them is 0.
- R8: A frame whose data, parity and stop bits are all 0 is reported with `break_det`=1, `frame_err`=1 and `rx_data`=0. No further character starts until the line has gone high again.
- R9: With `loop_en`=1 the receiver samples `loop_tx`, and `serial_in` has no effect. With `loop_en`=0 it samples `serial_in`.
- R10: The sample tick comes every `divisor` clocks, so one bit lasts 16·`divisor` clocks. A divisor of 0 or 1 gives one tick per clock. The serial input passes through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 16 | Clocks per sample tick |
| char_len | input | 2 | Data length select (5 to 8 bits) |
| par_mode | input | 2 | Bit 0 parity enable, bit 1 even select |
| stop_two | input | 1 | Expect two stop bits |
| loop_en | input | 1 | Receive from `loop_tx` instead of `serial_in` |
| serial_in | input | 1 | External serial line, idle high |
| loop_tx | input | 1 | Local transmitter output for loopback |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| parity_err | output | 1 | Parity mismatch on the last frame |
| frame_err | output | 1 | A stop bit of the last frame was 0 |
| break_det | output | 1 | The last frame was all zeros |

## Verification
A wrong tick phase or bit index shows within a single frame. The character comes out shifted or with its bits swapped, or the strobe arrives a bit early or late against the queue of expected characters. A start qualifier that is stuck open, or a break hold that is missing, shows as an extra unexpected character within about one frame time. A voter that trusts only one sample shows as a flipped bit in the same frame as the spike.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{DIV_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt_inc >= {1'b0, divisor}) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt_inc[DIV_W-1:0];
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic loop_en,
  input  logic serial_in,
  input  logic loop_tx,
  output logic line
);
  logic             raw;
  logic [STAGES-1:0] chain;

  assign raw = loop_en ? loop_tx : serial_in;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= raw;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b1;
      else     chain[g] <= chain[g-1];
    end
  end

  assign line = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_voter.sv
module uart_rx_voter
  import uart_rx_pkg::*;
#(
  parameter int OS   = 16,
  parameter int PH_W = $clog2(OS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            line,
  input  logic [PH_W-1:0] phase,
  output logic            vote
);
  localparam logic [PH_W-1:0] PH_EARLY = PH_W'(OS / 2 - 1);
  localparam logic [PH_W-1:0] PH_MID   = PH_W'(OS / 2);

  logic s_early, s_mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (tick) begin
      if (phase == PH_EARLY) s_early <= line;
      if (phase == PH_MID)   s_mid   <= line;
    end
  end

  assign vote = maj3(s_early, s_mid, line);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OS     = 16,
  parameter int PH_W   = $clog2(OS),
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              vote,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              stop_two,
  output logic [PH_W-1:0]   phase,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              parity_err,
  output logic              frame_err,
  output logic              break_det
);
  localparam int              IDX_W   = $clog2(DATA_W);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OS / 2);
  localparam logic [PH_W-1:0] PH_LATE = PH_W'(OS / 2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OS - 1);

  rx_state_e         state;
  logic [IDX_W-1:0]  bit_idx;
  logic              stop_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              all_zero;
  logic              ferr_acc;
  logic [1:0]        len_q;
  logic [1:0]        pmode_q;
  logic              stop2_q;

  logic [IDX_W-1:0]  last_idx;
  logic [PH_W-1:0]   ph_next;
  logic              exp_par;
  logic              brk_now;

  assign last_idx = IDX_W'(DATA_W - 4) + IDX_W'(len_q);
  assign ph_next  = (phase == PH_LAST) ? '0 : phase + 1'b1;
  assign exp_par  = pmode_q[1] ? (^shreg) : ~(^shreg);
  assign brk_now  = all_zero & ~vote;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= '0;
      bit_idx    <= '0;
      stop_idx   <= 1'b0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      all_zero   <= 1'b0;
      ferr_acc   <= 1'b0;
      len_q      <= '0;
      pmode_q    <= '0;
      stop2_q    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      break_det  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (state == ST_HOLD) begin
        if (line) state <= ST_IDLE;
      end else if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!line) begin
              state    <= ST_START;
              phase    <= PH_W'(1);
              bit_idx  <= '0;
              stop_idx <= 1'b0;
              shreg    <= '0;
              par_bit  <= 1'b0;
              all_zero <= 1'b1;
              ferr_acc <= 1'b0;
              len_q    <= char_len;
              pmode_q  <= par_mode;
              stop2_q  <= stop_two;
            end
          end
          ST_START: begin
            phase <= ph_next;
            if (phase == PH_MID && line) begin
              state <= ST_IDLE;
              phase <= '0;
            end else if (phase == PH_LAST) begin
              state <= ST_DATA;
            end
          end
          ST_DATA: begin
            phase <= ph_next;
            if (phase == PH_LATE) begin
              shreg[bit_idx] <= vote;
              all_zero       <= brk_now;
            end
            if (phase == PH_LAST) begin
              if (bit_idx == last_idx) state <= pmode_q[0] ? ST_PAR : ST_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end
          end
          ST_PAR: begin
            phase <= ph_next;
            if (phase == PH_LATE) begin
              par_bit  <= vote;
              all_zero <= brk_now;
            end
            if (phase == PH_LAST) state <= ST_STOP;
          end
          ST_STOP: begin
            phase <= ph_next;
            if (phase == PH_LATE) begin
              if (stop_idx == stop2_q) begin
                rx_valid   <= 1'b1;
                rx_data    <= shreg;
                parity_err <= pmode_q[0] & (par_bit != exp_par);
                frame_err  <= ferr_acc | ~vote;
                break_det  <= brk_now;
                state      <= brk_now ? ST_HOLD : ST_IDLE;
                phase      <= '0;
              end else begin
                ferr_acc <= ferr_acc | ~vote;
                all_zero <= brk_now;
              end
            end
            if (phase == PH_LAST) stop_idx <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int DIV_W       = 16,
  parameter int OS          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              stop_two,
  input  logic              loop_en,
  input  logic              serial_in,
  input  logic              loop_tx,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              parity_err,
  output logic              frame_err,
  output logic              break_det
);
  localparam int PH_W = $clog2(OS);

  logic            tick;
  logic            line;
  logic            vote;
  logic [PH_W-1:0] phase;

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .loop_en(loop_en), .serial_in(serial_in),
    .loop_tx(loop_tx), .line(line)
  );

  uart_rx_voter #(.OS(OS), .PH_W(PH_W)) u_voter (
    .clk(clk), .rst(rst), .tick(tick), .line(line), .phase(phase), .vote(vote)
  );

  uart_rx_fsm #(.OS(OS), .PH_W(PH_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .line(line), .vote(vote),
    .char_len(char_len), .par_mode(par_mode), .stop_two(stop_two),
    .phase(phase), .rx_data(rx_data), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err), .break_det(break_det)
  );
endmodule

// File: rtl/uart_rx_vote_chk.sv
module uart_rx_vote_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        char_len,
  input logic [1:0]        par_mode,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              parity_err,
  input logic              frame_err,
  input logic              break_det
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!rx_valid && rx_data == '0 && !parity_err && !frame_err && !break_det)); // R1

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(break_det))); // R2

  AST_SHORT_CHAR: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && char_len == 2'b00) |-> (rx_data[DATA_W-1:5] == '0)); // R3

  AST_NO_PAR_ERR: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !par_mode[0]) |-> !parity_err); // R4

  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && break_det) |-> (frame_err && rx_data == '0)); // R8
endmodule

bind uart_rx_vote uart_rx_vote_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .char_len(char_len), .par_mode(par_mode),
  .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
  .frame_err(frame_err), .break_det(break_det)
);

// File: tb/uart_rx_vote_bench.sv
module uart_rx_vote_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] divisor = 16'd4;
  logic [1:0]  char_len = 2'b11;
  logic [1:0]  par_mode = 2'b00;
  logic        stop_two = 1'b0;
  logic        loop_en = 1'b0;
  logic        serial_in = 1'b1;
  logic        loop_tx = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_valid, parity_err, frame_err, break_det;

  typedef struct {
    logic [7:0] d;
    bit pe;
    bit fe;
    bit bk;
    string req;
  } exp_t;

  exp_t  exp_q[$];
  string cur_req = "R1";
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [7:0] last_d = 8'h00;

  always #5 clk = ~clk;

  uart_rx_vote u_uart_rx_vote (
    .clk(clk), .rst(rst), .divisor(divisor), .char_len(char_len),
    .par_mode(par_mode), .stop_two(stop_two), .loop_en(loop_en),
    .serial_in(serial_in), .loop_tx(loop_tx), .rx_data(rx_data),
    .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err),
    .break_det(break_det)
  );

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected character: got %02h pe=%0b fe=%0b bk=%0b, expected none",
                 cur_req, rx_data, parity_err, frame_err, break_det);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        last_d = e.d;
        if (rx_data !== e.d || parity_err !== e.pe || frame_err !== e.fe || break_det !== e.bk) begin
          n_fail++;
          $display("FAIL %s got d=%02h pe=%0b fe=%0b bk=%0b, expected d=%02h pe=%0b fe=%0b bk=%0b",
                   e.req, rx_data, parity_err, frame_err, break_det, e.d, e.pe, e.fe, e.bk);
        end
      end
    end
  end

  function automatic int bit_clks();
    return 16 * ((divisor < 16'd2) ? 1 : int'(divisor));
  endfunction

  task automatic put_line(input logic v);
    if (loop_en) loop_tx = v;
    else serial_in = v;
  endtask

  task automatic hold(input int clks);
    repeat (clks) @(negedge clk);
  endtask

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    put_line(1'b1);
    hold(2 * bit_clks());
  endtask

  task automatic frame(input logic [7:0] d, input bit pbad, input bit s1bad,
                       input bit s2bad, input int glitch_bit, input string req);
    int nb;
    logic [7:0] dm;
    logic par;
    exp_t e;
    nb  = 5 + int'(char_len);
    dm  = d & 8'((1 << nb) - 1);
    par = par_mode[1] ? ^dm : ~(^dm);
    if (pbad) par = ~par;
    e.d   = dm;
    e.pe  = par_mode[0] && pbad;
    e.fe  = s1bad || (stop_two && s2bad);
    e.bk  = (dm == 0) && (!par_mode[0] || !par) && s1bad && (!stop_two || s2bad);
    e.req = req;
    cur_req = req;
    exp_q.push_back(e);
    put_line(1'b0);
    hold(bit_clks());
    for (int i = 0; i < nb; i++) begin
      put_line(dm[i]);
      if (i == glitch_bit) begin
        hold(31);
        put_line(~dm[i]);
        hold(4);
        put_line(dm[i]);
        hold(bit_clks() - 35);
      end else begin
        hold(bit_clks());
      end
    end
    if (par_mode[0]) begin
      put_line(par);
      hold(bit_clks());
    end
    put_line(!s1bad);
    hold(bit_clks());
    if (stop_two) begin
      put_line(!s2bad);
      hold(bit_clks());
    end
    put_line(1'b1);
    drain();
  endtask

  initial begin
    hold(5);
    check("R1 reset valid", rx_valid === 1'b0, rx_valid, 0);
    check("R1 reset data", rx_data === 8'h00, rx_data, 0);
    check("R1 reset flags", {parity_err, frame_err, break_det} === 3'b000,
          {parity_err, frame_err, break_det}, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {rx_valid, frame_err, break_det} === 3'b000,
          {rx_valid, frame_err, break_det}, 0);
    hold(64);

    // R2: 8N1, LSB first, several patterns
    frame(8'hA5, 0, 0, 0, -1, "R2 8N1 A5");
    frame(8'h01, 0, 0, 0, -1, "R2 8N1 01");
    frame(8'h80, 0, 0, 0, -1, "R2 8N1 80");
    frame(8'h3C, 0, 0, 0, -1, "R2 8N1 3C");
    hold(20);
    check("R2 data held", rx_data === last_d && rx_valid === 1'b0, rx_data, last_d);

    // R3: shorter lengths
    char_len = 2'b00; frame(8'hFF, 0, 0, 0, -1, "R3 len5");
    char_len = 2'b01; frame(8'h2B, 0, 0, 0, -1, "R3 len6");
    char_len = 2'b10; frame(8'h55, 0, 0, 0, -1, "R3 len7");
    char_len = 2'b11;

    // R4: parity
    par_mode = 2'b11; frame(8'h07, 0, 0, 0, -1, "R4 even ok");
    par_mode = 2'b01; frame(8'h07, 0, 0, 0, -1, "R4 odd ok");
    par_mode = 2'b11; frame(8'h5A, 1, 0, 0, -1, "R4 even bad");
    par_mode = 2'b01; frame(8'hC3, 1, 0, 0, -1, "R4 odd bad");
    par_mode = 2'b00;

    // R5: false start followed by a real character
    cur_req = "R5 false start";
    put_line(1'b0);
    hold(4 * 4);
    put_line(1'b1);
    hold(3 * bit_clks());
    frame(8'h96, 0, 0, 0, -1, "R5 after false start");

    // R6: single-sample spike inside bit 3
    frame(8'hFF, 0, 0, 0, 3, "R6 spike in 1");
    frame(8'h00, 0, 0, 0, 5, "R6 spike in 0");

    // R7: framing
    frame(8'h6E, 0, 1, 0, -1, "R7 stop low");
    stop_two = 1'b1;
    frame(8'h6E, 0, 0, 0, -1, "R7 two stops ok");
    frame(8'h6E, 0, 0, 1, -1, "R7 second stop low");
    stop_two = 1'b0;

    // R8: break, held low for several extra bit times
    begin
      exp_t e;
      e.d = 8'h00; e.pe = 1'b0; e.fe = 1'b1; e.bk = 1'b1; e.req = "R8 break";
      cur_req = "R8 break hold";
      exp_q.push_back(e);
      put_line(1'b0);
      hold(14 * bit_clks());
      put_line(1'b1);
      drain();
    end
    frame(8'h42, 0, 0, 0, -1, "R8 after break");

    // R9: loopback, serial_in held low
    loop_tx = 1'b1;
    loop_en = 1'b1;
    serial_in = 1'b0;
    hold(2 * bit_clks());
    frame(8'hD2, 0, 0, 0, -1, "R9 loopback");
    serial_in = 1'b1;
    hold(4);
    loop_en = 1'b0;
    hold(2 * bit_clks());

    // R10: other divisors
    divisor = 16'd7; hold(32);
    frame(8'h9B, 0, 0, 0, -1, "R10 divisor 7");
    divisor = 16'd1; hold(32);
    frame(8'h1E, 0, 0, 0, -1, "R10 divisor 1");
    divisor = 16'd0; hold(32);
    frame(8'hE1, 0, 0, 0, -1, "R10 divisor 0");

    check("R2 queue empty", exp_q.size() == 0, exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL %s watchdog expired: actual=running expected=finished", cur_req);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule